// File: doc/BRIEF.md
# Bidirectional Parallel Port with Open-Drain Mode

This block is an eight-bit general-purpose parallel port sitting on a simple memory-mapped register bus. Each pin has its own direction bit: a 1 makes the pin an output and a 0 leaves it an input. Software writes an output latch and a direction register, and reads back a data word that merges the latched value for output pins with the synchronized pad level for input pins.

The pad side uses an active-low tri-state enable, an output value and a raw input per bit. A single port-wide wire-OR bit changes every output pin from a push-pull driver into a drive-low-or-release driver, so several devices can share a line with an external pull-up. A port-wide override input hands the pads to another function, which supplies its own enables and values, without disturbing the port's registers.

Register select: 0 is the data latch, 1 is direction, 2 is control (bit 0 is the wire-OR mode, other bits read 0), and 3 is unused.

Top module: `pio_port`

## Requirements
- R1: After reset the direction and control registers read 0, the data latch is 0 and every `pad_oe_n` bit is 1.
- R2: With wire-OR mode 0, a pin whose direction bit is 1 has `pad_oe_n` 0 and `pad_out` equal to its latch bit.
- R3: A pin whose direction bit is 0 always has `pad_oe_n` 1, whatever its latch bit and the wire-OR mode.
- R4: With wire-OR mode 1, an output pin with latch 1 has `pad_oe_n` 1, and an output pin with latch 0 has `pad_oe_n` 0; every bit of `pad_out` is 0.
- R5: A read of select 0 returns the latch bit for output pins and the synchronized pad level for input pins.
- R6: A change on `pad_in` is not visible in read data after one rising clock edge and is visible after the second.
- R7: A write to select 0 updates latch bits of input pins too; the value drives the pad once the pin is turned to output.
- R8: While `alt_sel` is 1, `pad_oe_n` equals `alt_oe_n` and `pad_out` equals `alt_out`; when it returns to 0 the pads show the unchanged register state again.
- R9: Select 3 reads 0 and ignores writes; control bits other than bit 0 read 0; with `rd_en` 0 `rdata` is 0.
- R10: With `wr_en` 0 no register changes, whatever `addr` and `wdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when `rd_en` is 0 |
| pad_in | input | 8 | Raw pad levels |
| pad_oe_n | output | 8 | Active-low pad driver enables |
| pad_out | output | 8 | Pad output values |
| alt_sel | input | 1 | Hand pads to the alternate function |
| alt_oe_n | input | 8 | Alternate-function enables |
| alt_out | input | 8 | Alternate-function values |

## Verification
The bench targets the open-drain case with mixed latch values, where a design that kept driving high on a latch-1 output would fight the pull-up, and mixed direction masks, where a read mux with the select reversed returns pad levels for output pins. It checks the synchronizer depth on the exact edge, catching a design that exposes the pin after one flop or three. It writes the latch while pins are inputs, which exposes a design that drops those bits, and toggles the override to confirm the register state survives it.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } pio_sel_e;

  localparam int unsigned CTRL_WOR_BIT = 0;
endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] sync_q, sync_d;
  logic [1:0]   warm_q, warm_d;

  always_comb begin
    meta_d = d_i;
    sync_d = meta_q;
    warm_d = (warm_q == 2'd2) ? warm_q : warm_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      warm_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      warm_q <= warm_d;
    end
  end

  assign q_o = sync_q;

  // R6: output lags the pad by exactly two edges
  assert_sync_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] rdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] latch_q,
  output logic         wor_q
);
  logic [W-1:0] dir_d, latch_d;
  logic         wor_d;
  logic         dir_en, latch_en, wor_en;
  pio_sel_e     sel;

  assign sel = pio_sel_e'(addr);

  always_comb begin
    latch_en = wr_en && (sel == SEL_DATA);
    dir_en   = wr_en && (sel == SEL_DIR);
    wor_en   = wr_en && (sel == SEL_CTRL);
    latch_d  = latch_en ? wdata : latch_q;
    dir_d    = dir_en   ? wdata : dir_q;
    wor_d    = wor_en   ? wdata[CTRL_WOR_BIT] : wor_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      wor_q   <= 1'b0;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
      wor_q   <= wor_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_DATA: rdata = (dir_q & latch_q) | (~dir_q & pin_sync);
        SEL_DIR:  rdata = dir_q;
        SEL_CTRL: rdata[CTRL_WOR_BIT] = wor_q;
        default:  rdata = '0;
      endcase
    end
  end

  // R10: no write strobe, no register change
  assert_hold_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(latch_q) && $stable(dir_q) && $stable(wor_q)));
endmodule

// File: rtl/pio_drive.sv
module pio_drive #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] latch_q,
  input  logic         wor_q,
  input  logic         alt_sel,
  input  logic [W-1:0] alt_oe_n,
  input  logic [W-1:0] alt_out,
  output logic [W-1:0] pad_oe_n,
  output logic [W-1:0] pad_out
);
  logic [W-1:0] port_oe_n, port_out;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      if (!dir_q[b]) begin
        port_oe_n[b] = 1'b1;
        port_out[b]  = latch_q[b];
      end else if (wor_q) begin
        port_oe_n[b] = latch_q[b];
        port_out[b]  = 1'b0;
      end else begin
        port_oe_n[b] = 1'b0;
        port_out[b]  = latch_q[b];
      end
    end
  end

  assign pad_oe_n = alt_sel ? alt_oe_n : port_oe_n;
  assign pad_out  = alt_sel ? alt_out  : (wor_q ? '0 : port_out);

  // R3: input pins are never driven by the port
  assert_input_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_sel |-> ((~dir_q & ~pad_oe_n) == '0));
  // R4: wire-OR mode never drives a high level
  assert_wor_no_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_sel && wor_q) |-> ((~pad_oe_n & pad_out) == '0));
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe_n,
  output logic [W-1:0] pad_out,
  input  logic         alt_sel,
  input  logic [W-1:0] alt_oe_n,
  input  logic [W-1:0] alt_out
);
  logic         rst_sync_n;
  logic [W-1:0] pin_sync, dir_q, latch_q;
  logic         wor_q;

  pio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  pio_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(pad_in), .q_o(pin_sync)
  );

  pio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .pin_sync(pin_sync), .rdata(rdata),
    .dir_q(dir_q), .latch_q(latch_q), .wor_q(wor_q)
  );

  pio_drive #(.W(W)) u_drive (
    .clk(clk), .rst_n(rst_sync_n), .dir_q(dir_q), .latch_q(latch_q),
    .wor_q(wor_q), .alt_sel(alt_sel), .alt_oe_n(alt_oe_n),
    .alt_out(alt_out), .pad_oe_n(pad_oe_n), .pad_out(pad_out)
  );

  // R5: output pins read back their latch bits
  assert_read_latch_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && addr == SEL_DATA) |-> (((rdata ^ latch_q) & dir_q) == '0));
endmodule

// File: tb/pio_port_bench.sv
module pio_port_bench;
  localparam int W = 8;
  // fields: dir, ctrl, data, pin, exp_oe_n, exp_out, exp_rd
  localparam logic [55:0] VEC [6] = '{
    56'hFF_00_A5_00_00_A5_A5,
    56'h00_00_3C_C3_FF_3C_C3,
    56'hF0_00_12_AB_0F_12_1B,
    56'hFF_01_0F_00_0F_00_0F,
    56'h3C_01_55_FF_D7_00_D7,
    56'h81_00_7E_5A_7E_7E_5A
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, alt_sel = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [W-1:0] wdata = '0, pad_in = '0, alt_oe_n = '0, alt_out = '0;
  logic [W-1:0] rdata, pad_oe_n, pad_out;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pio_port #(.W(W)) u_pio_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_oe_n(pad_oe_n),
    .pad_out(pad_out), .alt_sel(alt_sel), .alt_oe_n(alt_oe_n),
    .alt_out(alt_out)
  );

  task automatic check(input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] v);
    @(negedge clk);
    addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    rd_en = 1'b0;
  endtask

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1 oe_n after reset", pad_oe_n, 8'hFF);
    rd(2'd1, v); check("R1 dir after reset", v, 8'h00);
    rd(2'd2, v); check("R1 ctrl after reset", v, 8'h00);
    rd(2'd0, v); check("R1 data after reset", v, 8'h00);

    for (int i = 0; i < 6; i++) begin
      logic [55:0] e;
      e = VEC[i];
      wr(2'd1, e[55:48]);
      wr(2'd2, e[47:40]);
      wr(2'd0, e[39:32]);
      pad_in = e[31:24];
      repeat (3) @(negedge clk);
      check(e[40] ? "R4 vector oe_n" : "R2/R3 vector oe_n", pad_oe_n, e[23:16]);
      check(e[40] ? "R4 vector out" : "R2 vector out", pad_out, e[15:8]);
      rd(2'd0, v); check("R5 vector read", v, e[7:0]);
    end

    // R6: synchronizer depth
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'hFF;
    @(negedge clk);
    rd(2'd0, v); check("R6 after one edge", v, 8'h00);
    @(negedge clk);
    rd(2'd0, v); check("R6 after two edges", v, 8'hFF);

    // R7: latch written while input
    wr(2'd0, 8'h99);
    check("R7 input still released", pad_oe_n, 8'hFF);
    wr(2'd1, 8'hFF);
    check("R7 latched value drives", pad_out, 8'h99);
    check("R7 enables on", pad_oe_n, 8'h00);
    rd(2'd0, v); check("R7 read latch", v, 8'h99);

    // R10: data on bus without strobe
    @(negedge clk);
    addr = 2'd0; wdata = 8'h00;
    repeat (2) @(negedge clk);
    rd(2'd0, v); check("R10 latch unchanged", v, 8'h99);
    check("R10 pads unchanged", pad_out, 8'h99);

    // R8: override
    @(negedge clk);
    alt_sel = 1'b1; alt_oe_n = 8'h0F; alt_out = 8'hC6;
    #1;
    check("R8 override oe_n", pad_oe_n, 8'h0F);
    check("R8 override out", pad_out, 8'hC6);
    @(negedge clk);
    alt_sel = 1'b0;
    #1;
    check("R8 restore oe_n", pad_oe_n, 8'h00);
    check("R8 restore out", pad_out, 8'h99);

    // R9: unused select, control width, read strobe
    wr(2'd3, 8'hFF);
    rd(2'd3, v); check("R9 unused reads 0", v, 8'h00);
    rd(2'd0, v); check("R9 unused write ignored", v, 8'h99);
    wr(2'd2, 8'hFE);
    rd(2'd2, v); check("R9 ctrl upper bits 0", v, 8'h00);
    wr(2'd2, 8'hFF);
    rd(2'd2, v); check("R9 ctrl bit0", v, 8'h01);
    addr = 2'd0; rd_en = 1'b0;
    #1 check("R9 no strobe reads 0", rdata, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule